// File: doc/BRIEF.md
# Multi-Mode Pixel Input Formatter

This block sits between a 16-bit pixel data port and a display output path. It turns raw input words into complete pixels, either as 8-bit palette indices or as 8-bit red, green and blue values. A static 4-bit format code chooses how the words are read. Single-clock formats decode one pixel per word. A dual-lane format gives two indices per word. Serial formats build one pixel from two or three successive words. A packed format unpacks two 24-bit pixels from every three words. An active-data qualifier marks the cycles that carry pixel data. Its rising sample also starts the first byte or word of a multi-clock pixel.

The output is a stream with a valid strobe and no ready. The receiving logic must take every pixel in the cycle it is presented, because the block cannot stall its source. Each pixel appears one clock after the edge that sampled its last input word. Output fields that do not apply to the pixel's kind read as zero.

Top module: `pxf_top`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, every output is zero.
- R2: Format 4'h0 (one index per word): `idx0` equals `pix_in[7:0]` of the word sampled at the previous edge, with `pix_valid` high and `pix_true` low; `pix_in[15:8]` has no effect.
- R3: Format 4'h1 (15-bit color): red is `pix_in[14:10]`, green `pix_in[9:5]`, blue `pix_in[4:0]`, each widened to 8 bits by appending zero low bits; `pix_in[15]` has no effect.
- R4: Format 4'h3 (16-bit color): red is `pix_in[15:11]` and blue `pix_in[4:0]`, each with three zero low bits appended; green is `pix_in[10:5]` with two zero low bits appended.
- R5: Format 4'h2 (two indices per word): `idx0` is `pix_in[7:0]` (the earlier pixel), `idx1` is `pix_in[15:8]`, and `pix_dual` is high. `pix_dual` is high in no other format.
- R6: Format 4'h4 (nibble serial): the first active word gives index bits [3:0] from `pix_in[3:0]`, and the second gives bits [7:4]; `pix_in[15:4]` has no effect, and valid appears only after the second word.
- R7: Format 4'h5 (two-word 24-bit): the first word gives green in [15:8] and blue in [7:0], and the second gives red in [7:0]; the second word's [15:8] has no effect.
- R8: Format 4'h6 (two-byte 16-bit color): bytes arrive on `pix_in[7:0]`, low byte first then high byte, and the assembled word is decoded as in R4; `pix_in[15:8]` has no effect.
- R9: Format 4'h7 (three-byte 24-bit): blue, then green, then red arrive on `pix_in[7:0]`, and valid appears after red; `pix_in[15:8]` has no effect.
- R10: Format 4'hE (packed 24-bit): three words hold pixel A {green[15:8], blue[7:0]}, then {B blue[15:8], A red[7:0]}, then {B red[15:8], B green[7:0]}. Pixel A is valid after the second word and pixel B after the third.
- R11: A cycle with `act_i` low yields no valid pixel and discards any partial pixel. The next active word is the first part of a new pixel. Words keep arriving back to back while `act_i` stays high.
- R12: Codes 4'h8 to 4'hD and 4'hF are reserved and never raise `pix_valid`.
- R13: `pix_true` is high for the color formats (1, 3, 5, 6, 7, E) and low for the index formats (0, 2, 4). On a valid index pixel, red, green and blue are zero. On a valid color pixel, `idx0` and `idx1` are zero. When no pixel is valid, every data output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_mode | input | 4 | Static input format code |
| act_i | input | 1 | High while the input word carries pixel data |
| pix_in | input | 16 | Input data word |
| pix_valid | output | 1 | A complete pixel is on the outputs this cycle |
| pix_true | output | 1 | High for a color pixel, low for an index pixel |
| pix_dual | output | 1 | Second index lane `idx1` also carries a pixel |
| idx0 | output | 8 | Palette index, first lane |
| idx1 | output | 8 | Palette index, second lane |
| red | output | 8 | Red component |
| green | output | 8 | Green component |
| blue | output | 8 | Blue component |

## Verification
The bench runs long back-to-back streams in every format. It puts deliberate junk in the bits each format must ignore, so a design that leaked an unused byte or nibble into a pixel would show wrong values. It drops `act_i` partway through serial and packed pixels and then checks that the next word starts a fresh pixel. A phase counter that failed to clear would emit a pixel built from stale and new words, or shift the byte order of every later pixel. Byte and lane order in the packed and dual formats are checked against arithmetic expectations, which catches a swapped byte or lane. Reserved codes are streamed to confirm that no pixel ever appears.

// File: rtl/pxf_pkg.sv
package pxf_pkg;
  localparam int unsigned IN_W = 16;
  localparam int unsigned CH_W = 8;
  localparam int unsigned PH_W = 2;

  typedef enum logic [3:0] {
    FM_IDX8   = 4'h0,
    FM_RGB555 = 4'h1,
    FM_IDX8X2 = 4'h2,
    FM_RGB565 = 4'h3,
    FM_NIB    = 4'h4,
    FM_W2     = 4'h5,
    FM_B2     = 4'h6,
    FM_B3     = 4'h7,
    FM_PK24   = 4'hE
  } fmt_e;

  typedef struct packed {
    logic            vld;
    logic            tc;
    logic            dual;
    logic [CH_W-1:0] i0;
    logic [CH_W-1:0] i1;
    logic [CH_W-1:0] r;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] b;
  } pix_t;

  // number of input words that make up one assembly cycle
  function automatic logic [PH_W-1:0] fmt_len(input logic [3:0] m);
    case (m)
      FM_NIB, FM_W2, FM_B2: fmt_len = PH_W'(2);
      FM_B3, FM_PK24:       fmt_len = PH_W'(3);
      default:              fmt_len = PH_W'(1);
    endcase
  endfunction

  function automatic logic [CH_W-1:0] wid5(input logic [4:0] x);
    wid5 = {x, {(CH_W-5){1'b0}}};
  endfunction

  function automatic logic [CH_W-1:0] wid6(input logic [5:0] x);
    wid6 = {x, {(CH_W-6){1'b0}}};
  endfunction
endpackage

// File: rtl/pxf_phase.sv
module pxf_phase
  import pxf_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      mode,
  input  logic            act,
  input  logic [IN_W-1:0] din,
  output logic [PH_W-1:0] ph,
  output logic [IN_W-1:0] w0,
  output logic [IN_W-1:0] w1
);
  logic [PH_W-1:0] last_ph;
  assign last_ph = fmt_len(mode) - PH_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= '0;
      w0 <= '0;
      w1 <= '0;
    end else if (!act) begin
      ph <= '0;
    end else begin
      ph <= (ph == last_ph) ? '0 : ph + PH_W'(1);
      if (ph == PH_W'(0)) w0 <= din;
      if (ph == PH_W'(1)) w1 <= din;
    end
  end
endmodule

// File: rtl/pxf_decode.sv
module pxf_decode
  import pxf_pkg::*;
(
  input  logic [3:0]      mode,
  input  logic            act,
  input  logic [IN_W-1:0] din,
  input  logic [PH_W-1:0] ph,
  input  logic [IN_W-1:0] w0,
  input  logic [IN_W-1:0] w1,
  output pix_t            px
);
  logic [IN_W-1:0] pair_w;
  assign pair_w = {din[7:0], w0[7:0]};

  always_comb begin
    px = '0;
    if (act) begin
      case (mode)
        FM_IDX8: begin
          px.vld = 1'b1;
          px.i0  = din[7:0];
        end
        FM_IDX8X2: begin
          px.vld  = 1'b1;
          px.dual = 1'b1;
          px.i0   = din[7:0];
          px.i1   = din[15:8];
        end
        FM_RGB555: begin
          px.vld = 1'b1;
          px.tc  = 1'b1;
          px.r   = wid5(din[14:10]);
          px.g   = wid5(din[9:5]);
          px.b   = wid5(din[4:0]);
        end
        FM_RGB565: begin
          px.vld = 1'b1;
          px.tc  = 1'b1;
          px.r   = wid5(din[15:11]);
          px.g   = wid6(din[10:5]);
          px.b   = wid5(din[4:0]);
        end
        FM_NIB: if (ph == PH_W'(1)) begin
          px.vld = 1'b1;
          px.i0  = {din[3:0], w0[3:0]};
        end
        FM_W2: if (ph == PH_W'(1)) begin
          px.vld = 1'b1;
          px.tc  = 1'b1;
          px.r   = din[7:0];
          px.g   = w0[15:8];
          px.b   = w0[7:0];
        end
        FM_B2: if (ph == PH_W'(1)) begin
          px.vld = 1'b1;
          px.tc  = 1'b1;
          px.r   = wid5(pair_w[15:11]);
          px.g   = wid6(pair_w[10:5]);
          px.b   = wid5(pair_w[4:0]);
        end
        FM_B3: if (ph == PH_W'(2)) begin
          px.vld = 1'b1;
          px.tc  = 1'b1;
          px.b   = w0[7:0];
          px.g   = w1[7:0];
          px.r   = din[7:0];
        end
        FM_PK24: begin
          if (ph == PH_W'(1)) begin
            px.vld = 1'b1;
            px.tc  = 1'b1;
            px.r   = din[7:0];
            px.g   = w0[15:8];
            px.b   = w0[7:0];
          end else if (ph == PH_W'(2)) begin
            px.vld = 1'b1;
            px.tc  = 1'b1;
            px.b   = w1[15:8];
            px.g   = din[7:0];
            px.r   = din[15:8];
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pxf_top.sv
module pxf_top
  import pxf_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      fmt_mode,
  input  logic            act_i,
  input  logic [IN_W-1:0] pix_in,
  output logic            pix_valid,
  output logic            pix_true,
  output logic            pix_dual,
  output logic [CH_W-1:0] idx0,
  output logic [CH_W-1:0] idx1,
  output logic [CH_W-1:0] red,
  output logic [CH_W-1:0] green,
  output logic [CH_W-1:0] blue
);
  logic [PH_W-1:0] ph;
  logic [IN_W-1:0] w0, w1;
  pix_t            px_d, px_q;

  pxf_phase u_phase (
    .clk  (clk),
    .rst_n(rst_n),
    .mode (fmt_mode),
    .act  (act_i),
    .din  (pix_in),
    .ph   (ph),
    .w0   (w0),
    .w1   (w1)
  );

  pxf_decode u_decode (
    .mode(fmt_mode),
    .act (act_i),
    .din (pix_in),
    .ph  (ph),
    .w0  (w0),
    .w1  (w1),
    .px  (px_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) px_q <= '0;
    else        px_q <= px_d;
  end

  assign pix_valid = px_q.vld;
  assign pix_true  = px_q.tc;
  assign pix_dual  = px_q.dual;
  assign idx0      = px_q.i0;
  assign idx1      = px_q.i1;
  assign red       = px_q.r;
  assign green     = px_q.g;
  assign blue      = px_q.b;
endmodule

// File: rtl/pxf_chk.sv
module pxf_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] fmt_mode,
  input logic       act_i,
  input logic       pix_valid,
  input logic       pix_true,
  input logic       pix_dual,
  input logic [7:0] idx0,
  input logic [7:0] idx1,
  input logic [7:0] red,
  input logic [7:0] green,
  input logic [7:0] blue
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> !pix_valid);

  // R11
  act_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> $past(act_i));

  // R12
  reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> (fmt_mode <= 4'h7 || fmt_mode == 4'hE));

  // R5
  dual_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_dual |-> (pix_valid && fmt_mode == 4'h2));

  // R13
  index_rgb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_true) |-> ((red | green | blue) == 8'h00));

  // R13
  color_idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_true) |-> ((idx0 | idx1) == 8'h00));

  // R3
  zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && (fmt_mode == 4'h1 || fmt_mode == 4'h3 || fmt_mode == 4'h6))
      |-> (red[2:0] == 3'b000 && blue[2:0] == 3'b000 && green[1:0] == 2'b00));

  // R6
  nibble_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && fmt_mode == 4'h4) |=> !pix_valid);

  // R9
  triplet_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && fmt_mode == 4'h7) |=> !pix_valid);
endmodule

bind pxf_top pxf_chk u_chk (.*);

// File: tb/test_pxf_top.sv
module test_pxf_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  fmt_mode = 4'h0;
  logic        act_i = 1'b0;
  logic [15:0] pix_in = 16'h0;
  logic        pix_valid, pix_true, pix_dual;
  logic [7:0]  idx0, idx1, red, green, blue;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  pxf_top i_pxf_top (
    .clk(clk), .rst_n(rst_n), .fmt_mode(fmt_mode), .act_i(act_i), .pix_in(pix_in),
    .pix_valid(pix_valid), .pix_true(pix_true), .pix_dual(pix_dual),
    .idx0(idx0), .idx1(idx1), .red(red), .green(green), .blue(blue)
  );

  function automatic logic [15:0] mix(input int i);
    logic [31:0] t;
    t = 32'(i) * 32'd2654435761 + 32'd977;
    return t[31:16] ^ t[15:0];
  endfunction

  localparam logic [42:0] E_NONE = 43'd0;
  function automatic logic [42:0] e_idx(input logic [7:0] v);
    return {3'b100, v, 8'd0, 24'd0};
  endfunction
  function automatic logic [42:0] e_dual(input logic [7:0] a, input logic [7:0] b);
    return {3'b101, a, b, 24'd0};
  endfunction
  function automatic logic [42:0] e_rgb(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
    return {3'b110, 16'd0, r, g, b};
  endfunction
  function automatic logic [42:0] e_565(input logic [15:0] w);
    return e_rgb({w[15:11], 3'b0}, {w[10:5], 2'b0}, {w[4:0], 3'b0});
  endfunction
  function automatic logic [42:0] e_555(input logic [15:0] w);
    return e_rgb({w[14:10], 3'b0}, {w[9:5], 3'b0}, {w[4:0], 3'b0});
  endfunction

  // drive one word, let the edge sample it, look just after the edge
  task automatic cyc(input logic a, input logic [15:0] d);
    act_i  = a;
    pix_in = d;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [42:0] exp);
    logic [42:0] got;
    got = {pix_valid, pix_true, pix_dual, idx0, idx1, red, green, blue};
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic idle(input logic [3:0] m);
    cyc(1'b0, 16'hFFFF);
    chk("R11", E_NONE);
    fmt_mode = m;
  endtask

  initial begin
    repeat (250000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog got hung run expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R1 reset
    act_i = 1'b1;
    pix_in = 16'hA5A5;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", E_NONE);
    rst_n = 1'b1;
    chk("R1", E_NONE);
    idle(4'h0);

    // R2 and R13 single index
    for (int i = 0; i < 2048; i++) begin
      logic [15:0] w;
      w = mix(i);
      cyc(1'b1, w);
      chk("R2", e_idx(w[7:0]));
    end
    cyc(1'b0, 16'h1234);
    chk("R13", E_NONE);

    idle(4'h1);
    for (int i = 0; i < 2048; i++) begin
      logic [15:0] w;
      w = mix(i + 3000);
      cyc(1'b1, w);
      chk("R3", e_555(w));
    end

    idle(4'h3);
    for (int i = 0; i < 2048; i++) begin
      logic [15:0] w;
      w = mix(i + 6000);
      cyc(1'b1, w);
      chk("R4", e_565(w));
    end

    idle(4'h2);
    for (int i = 0; i < 2048; i++) begin
      logic [15:0] w;
      w = mix(i + 9000);
      cyc(1'b1, w);
      chk("R5", e_dual(w[7:0], w[15:8]));
    end

    idle(4'h4);
    for (int i = 0; i < 1024; i++) begin
      logic [15:0] j;
      logic [7:0]  v;
      j = mix(i + 12000);
      v = mix(i + 15000)[7:0];
      cyc(1'b1, {j[15:4], v[3:0]});
      chk("R6", E_NONE);
      cyc(1'b1, {~j[15:4], v[7:4]});
      chk("R6", e_idx(v));
    end
    // R11 break mid-nibble
    cyc(1'b1, 16'h000F);
    cyc(1'b0, 16'h0003);
    chk("R11", E_NONE);
    cyc(1'b1, 16'hFFF2);
    chk("R11", E_NONE);
    cyc(1'b1, 16'h0009);
    chk("R11", e_idx(8'h92));

    idle(4'h5);
    for (int i = 0; i < 1024; i++) begin
      logic [15:0] a, b;
      a = mix(i + 20000);
      b = mix(i + 23000);
      cyc(1'b1, a);
      chk("R7", E_NONE);
      cyc(1'b1, b);
      chk("R7", e_rgb(b[7:0], a[15:8], a[7:0]));
    end

    idle(4'h6);
    for (int i = 0; i < 1024; i++) begin
      logic [15:0] w, j;
      w = mix(i + 26000);
      j = mix(i + 29000);
      cyc(1'b1, {j[15:8], w[7:0]});
      chk("R8", E_NONE);
      cyc(1'b1, {j[7:0], w[15:8]});
      chk("R8", e_565(w));
    end

    idle(4'h7);
    for (int i = 0; i < 1024; i++) begin
      logic [15:0] c, j;
      c = mix(i + 32000);
      j = mix(i + 35000);
      cyc(1'b1, {j[7:0], c[7:0]});
      chk("R9", E_NONE);
      cyc(1'b1, {j[15:8], c[15:8]});
      chk("R9", E_NONE);
      cyc(1'b1, {c[7:0], j[7:0]});
      chk("R9", e_rgb(j[7:0], c[15:8], c[7:0]));
    end
    // R11 break after two bytes
    cyc(1'b1, 16'h0011);
    cyc(1'b1, 16'h0022);
    cyc(1'b0, 16'h0033);
    chk("R11", E_NONE);
    cyc(1'b1, 16'h0044);
    cyc(1'b1, 16'h0055);
    chk("R11", E_NONE);
    cyc(1'b1, 16'h0066);
    chk("R11", e_rgb(8'h66, 8'h55, 8'h44));

    idle(4'hE);
    for (int i = 0; i < 1024; i++) begin
      logic [15:0] x, y, z;
      x = mix(3 * i + 40000);
      y = mix(3 * i + 40001);
      z = mix(3 * i + 40002);
      cyc(1'b1, x);
      chk("R10", E_NONE);
      cyc(1'b1, y);
      chk("R10", e_rgb(y[7:0], x[15:8], x[7:0]));
      cyc(1'b1, z);
      chk("R10", e_rgb(z[15:8], z[7:0], y[15:8]));
    end
    // R11 break inside a packed group
    cyc(1'b1, 16'hDEAD);
    cyc(1'b0, 16'hBEEF);
    chk("R11", E_NONE);
    cyc(1'b1, 16'h2211);
    chk("R11", E_NONE);
    cyc(1'b1, 16'h4433);
    chk("R11", e_rgb(8'h33, 8'h22, 8'h11));
    cyc(1'b1, 16'h6655);
    chk("R11", e_rgb(8'h66, 8'h55, 8'h44));

    // R12 reserved codes
    for (int m = 8; m < 16; m++) begin
      if (m != 14) begin
        idle(4'(m));
        for (int k = 0; k < 64; k++) begin
          cyc(1'b1, mix(k + 50000 + 100 * m));
          chk("R12", E_NONE);
        end
      end
    end

    cyc(1'b0, 16'h0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule